// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

This block sits on the host side of a two-wire serial bus. It is used after a write to a nonvolatile memory slave has been loaded and closed with a STOP. While the slave runs its internal programming cycle, it ignores the bus and gives no acknowledge to its own address. The sequencer uses this silence as a busy indication. It probes the slave over and over until the address is acknowledged, and then hands the still-open transaction back to the user.

Polling starts in the cycle after a `start` pulse, with no wait state first. Each probe is a START followed by the address byte, which is the 7-bit device address above a direction bit. Then comes an acknowledge read. A missing acknowledge is followed by a STOP and a fresh probe. An acknowledge ends the loop with no STOP, so the pending read or write can go on in the same transaction. A limit on failed probes, loaded together with the request, bounds the loop. When the limit runs out, the sequencer closes the bus with a STOP and reports a timeout.

Every bus action goes to a bit-level master through a valid/ready command port. The command codes are START = 0, SEND byte = 1, read ACK = 2 and STOP = 3. A command counts as executed in a cycle where both `cmd_valid` and `cmd_ready` are high. For a read-ACK command, `ack_in` is sampled in that same cycle, and 1 means the slave acknowledged.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `cmd_valid`, `done`, `acked` and `timeout` are low, and no command is offered until a `start` pulse arrives.
- R2: Every probe offers START (code 0), then SEND (code 1) with `cmd_byte = {dev_addr, rd_nwr}` (address in bits 7:1, direction in bit 0), then read ACK (code 2), in that order.
- R3: When a read-ACK command executes with `ack_in` low and the limit is not yet reached, the next command is STOP (code 3), and it is followed by a new probe that starts with START.
- R4: When a read-ACK command executes with `ack_in` high, `done` and `acked` pulse in the next cycle, `cmd_valid` falls, and no STOP is issued.
- R5: With a limit N ≥ 1 latched at `start`, the N-th probe without an acknowledge is followed by a STOP. After that STOP executes, `done` and `timeout` pulse in the next cycle, and no further probe is made.
- R6: A limit of 0 behaves as a limit of 1: exactly one probe is made.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold their values.
- R8: `done` is high for exactly one cycle per request. In that cycle exactly one of `acked` and `timeout` is high, and neither is high without `done`.
- R9: A `start` pulse while a request is in progress is ignored: the address byte, the limit and the command sequence of the running request do not change.
- R10: A `start` in the idle state makes `cmd_valid` rise with START in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| dev_addr | input | ADDR_W | 7-bit slave address of the request |
| rd_nwr | input | 1 | Direction bit placed in the probe byte (1 = read) |
| max_probes | input | CNT_W | Limit on failed probes (0 is treated as 1) |
| done | output | 1 | One-cycle completion pulse |
| acked | output | 1 | With `done`: the slave acknowledged, and the bus is left open |
| timeout | output | 1 | With `done`: the probe limit was exhausted, and the bus is closed |
| cmd_valid | output | 1 | Command offered to the bit-level master |
| cmd_ready | input | 1 | Bit-level master accepts or completes the command |
| cmd_op | output | 2 | Command code: 0 START, 1 SEND, 2 read ACK, 3 STOP |
| cmd_byte | output | ADDR_W+1 | Byte for SEND |
| ack_in | input | 1 | Acknowledge result, valid with a read-ACK handshake |

## Verification
The bench builds the block with `CNT_W = 4`, so that the largest limit, 15, can be driven to exhaustion in a short run. With this width the bench can reach a slave that answers on exactly the last allowed probe, a slave that stays busy through all fifteen, and the limit-zero case. It varies the handshake latency of the bit-level master so that commands are held across several wait cycles, and it sends requests with both direction bits and with varied addresses.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              rd_nwr,
  input  logic [CNT_W-1:0]  max_probes,
  output logic              done,
  output logic              acked,
  output logic              timeout,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_byte,
  input  logic              ack_in
);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_SEND  = 2'd1;
  localparam logic [1:0] OP_ACK   = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_SEND, S_ACK, S_STOP} st_t;

  st_t              st;
  logic [ADDR_W:0]  byte_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] fails;
  logic             give_up;

  logic             hs;
  logic [CNT_W:0]   fails_nxt;
  logic [CNT_W:0]   lim_eff;
  logic             spent;

  assign hs        = cmd_valid && cmd_ready;
  assign fails_nxt = {1'b0, fails} + 1'b1;
  assign lim_eff   = (lim_q == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, lim_q};
  assign spent     = fails_nxt >= lim_eff;

  assign cmd_valid = (st != S_IDLE);
  assign cmd_byte  = byte_q;

  always_comb begin
    case (st)
      S_SEND:  cmd_op = OP_SEND;
      S_ACK:   cmd_op = OP_ACK;
      S_STOP:  cmd_op = OP_STOP;
      default: cmd_op = OP_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      byte_q  <= '0;
      lim_q   <= '0;
      fails   <= '0;
      give_up <= 1'b0;
      done    <= 1'b0;
      acked   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      acked   <= 1'b0;
      timeout <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          byte_q  <= {dev_addr, rd_nwr};
          lim_q   <= max_probes;
          fails   <= '0;
          give_up <= 1'b0;
          st      <= S_START;
        end
        S_START: if (hs) st <= S_SEND;
        S_SEND:  if (hs) st <= S_ACK;
        S_ACK: if (hs) begin
          if (ack_in) begin
            done  <= 1'b1;
            acked <= 1'b1;
            st    <= S_IDLE;
          end else begin
            fails   <= fails_nxt[CNT_W-1:0];
            give_up <= spent;
            st      <= S_STOP;
          end
        end
        S_STOP: if (hs) begin
          if (give_up) begin
            done    <= 1'b1;
            timeout <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st <= S_START;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_probe_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_op == OP_START |=> cmd_valid && cmd_op == OP_SEND);

  p_send_then_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_op == OP_SEND |=> cmd_valid && cmd_op == OP_ACK);

  p_nack_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_op == OP_ACK && !ack_in |=> cmd_valid && cmd_op == OP_STOP);

  p_ack_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_op == OP_ACK && ack_in |=> done && acked && !cmd_valid);

  p_timeout_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(hs && cmd_op == OP_STOP));

  p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done == (acked || timeout) && !(acked && timeout));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && $past(cmd_valid) |-> $stable(cmd_byte));

  p_go_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && start |=> cmd_valid && cmd_op == OP_START);

endmodule

// File: tb/ack_poll_seq_tb.sv
module ack_poll_seq_tb;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] dev_addr = '0;
  logic              rd_nwr = 1'b0;
  logic [CNT_W-1:0]  max_probes = '0;
  logic              done, acked, timeout, cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [1:0]        cmd_op;
  logic [ADDR_W:0]   cmd_byte;
  logic              ack_in = 1'b0;

  ack_poll_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .rd_nwr(rd_nwr), .max_probes(max_probes), .done(done), .acked(acked),
    .timeout(timeout), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .ack_in(ack_in));

  always #2 clk = ~clk;

  // item = {code, byte}; codes 0..3 commands, 4 acked, 5 timeout
  logic [10:0] exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int busy_left = 0;
  int wcnt = 0;
  int lat_seed = 0;
  int seen_done = 0;
  int cyc = 0;
  logic waiting = 1'b0;
  logic [1:0] hold_op;
  logic [ADDR_W:0] hold_byte;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take(input int code, input int byt, input string req);
    logic [10:0] e;
    if (exp_q.size() == 0) begin
      check(1'b0, req, code, 7);
    end else begin
      e = exp_q.pop_front();
      if (code == 1)
        check(e[10:8] == 3'(code) && e[7:0] == 8'(byt), req, {code, byt[7:0]}, int'(e));
      else
        check(e[10:8] == 3'(code), req, code, int'(e[10:8]));
    end
  endtask

  // bit-level master model and monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (waiting) begin
        check(cmd_valid && cmd_op == hold_op && cmd_byte == hold_byte, "R7",
              {cmd_op, cmd_byte}, {hold_op, hold_byte});
        waiting = 1'b0;
      end
      if (done) begin
        seen_done++;
        check(acked ^ timeout, "R8", {acked, timeout}, 1);
        take(acked ? 4 : 5, 0, acked ? "R4" : "R5");
      end else begin
        check(!acked && !timeout, "R8", {acked, timeout}, 0);
      end
      if (cmd_ready) begin
        cmd_ready = 1'b0;
      end else if (cmd_valid) begin
        if (wcnt > 0) begin
          wcnt--;
          waiting = 1'b1;
          hold_op = cmd_op;
          hold_byte = cmd_byte;
        end else begin
          cmd_ready = 1'b1;
          take(int'(cmd_op), int'(cmd_byte), cmd_op == 2'd3 ? "R3" : "R2");
          if (cmd_op == 2'd2) begin
            ack_in = (busy_left == 0);
            if (busy_left > 0) busy_left--;
          end
          lat_seed++;
          wcnt = lat_seed % 3;
        end
      end
    end
  end

  task automatic run_poll(input int addr, input bit dir, input int busy, input int lim,
                          input bit poke_busy);
    int eff, fails;
    bit to;
    logic [7:0] b;
    eff = (lim == 0) ? 1 : lim;
    to = (busy >= eff);
    fails = to ? eff : busy;
    b = {addr[6:0], dir};
    for (int i = 0; i < fails; i++) begin
      exp_q.push_back({3'd0, 8'h0});
      exp_q.push_back({3'd1, b});
      exp_q.push_back({3'd2, 8'h0});
      exp_q.push_back({3'd3, 8'h0});
    end
    if (to) begin
      exp_q.push_back({3'd5, 8'h0});
    end else begin
      exp_q.push_back({3'd0, 8'h0});
      exp_q.push_back({3'd1, b});
      exp_q.push_back({3'd2, 8'h0});
      exp_q.push_back({3'd4, 8'h0});
    end
    busy_left = busy;
    seen_done = 0;
    dev_addr = addr[6:0];
    rd_nwr = dir;
    max_probes = CNT_W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cmd_valid && cmd_op == 2'd0, "R10", {cmd_valid, cmd_op}, 4);
    if (poke_busy) begin
      // R9: a second request mid-run must change nothing
      repeat (3) @(negedge clk);
      dev_addr = ~addr[6:0];
      rd_nwr = ~dir;
      max_probes = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (seen_done == 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0 && !cmd_valid, poke_busy ? "R9" : "R4", exp_q.size(), 0);
    check(seen_done == 1, "R8", seen_done, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cmd_valid && !done && !acked && !timeout, "R1",
          {cmd_valid, done, acked, timeout}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cmd_valid && !done, "R1", {cmd_valid, done}, 0);
    run_poll(7'h50, 1'b0, 0, 5, 1'b0);   // R4 immediate acknowledge
    run_poll(7'h2A, 1'b1, 3, 5, 1'b0);   // R3 busy for three probes
    run_poll(7'h51, 1'b0, 4, 5, 1'b0);   // R3 acknowledge on last allowed probe
    run_poll(7'h13, 1'b1, 5, 5, 1'b0);   // R5 busy through limit
    run_poll(7'h7F, 1'b0, 2, 0, 1'b0);   // R6 limit zero gives one probe
    run_poll(7'h00, 1'b1, 0, 0, 1'b0);   // R6 limit zero, ready slave
    run_poll(7'h3C, 1'b0, 14, 15, 1'b0); // R3 full-range limit, late acknowledge
    run_poll(7'h41, 1'b1, 20, 15, 1'b0); // R5 full-range exhaustion
    run_poll(7'h66, 1'b0, 6, 9, 1'b1);   // R9 start ignored while busy
    run_poll(7'h19, 1'b1, 3, 2, 1'b1);   // R9 plus R5
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule